// File: doc/BRIEF.md
# Translation Context Qualifier

This block sits at the front of an address translation unit. For every memory access it first decides whether translation applies at all. It makes that decision from the access type and two relocation enables: one for instruction fetches and one for data accesses. When translation is off, the block returns a real address straight away, with full access rights.

When translation is on, the block uses the top two bits of the effective address to pick the process context. One quadrant belongs to applications and uses the process ID register. One belongs to the operating system and forces process ID zero. The remaining two quadrants are illegal and end in a segment fault.

For a legal context, the block checks the process table offset against the table size. It then reads the first word of the process table entry through a valid/ready read port. It returns that word, together with the partition and process IDs, so the table walk that follows can use them.

Each accepted request ends in exactly one done pulse. The pulse carries one of three results: a real-mode address, a fetched entry word, or a fault code. Only one request is in flight at a time.

Top module: `xlat_ctx_qual`

## Requirements
- R1: Real mode applies to a fetch (req_acc=2) exactly when ir_en=0, and to any other access code (0 load, 1 store, 3 treated as data) exactly when dr_en=0. The other enable has no effect on the decision.
- R2: A real-mode result has done_kind=0, done_addr equal to req_ea with its top 4 bits cleared, and done_perm=3'b111 (read, write, execute). It makes no memory read. It takes priority over the quadrant and bounds checks.
- R3: With translation on and address quadrant req_ea[63:62]=0, the context uses part_id as the partition ID and proc_id as the process ID.
- R4: With translation on and quadrant 3, the process ID is forced to 0 whatever proc_id holds, and part_id is still used.
- R5: Quadrants 1 and 2 on a translated fetch give done_kind=2, done_fault=1 (instruction segment fault) and done_addr=0, with no memory read.
- R6: Quadrants 1 and 2 on a translated data access give done_kind=2, done_fault=2 (data segment fault) and done_addr equal to req_ea, with no memory read.
- R7: The entry offset is the process ID times 16. If that offset is greater than or equal to 2^(ptab_size+12) bytes, the result is a no-translation storage fault (done_fault=3 with done_addr=0 for a fetch, done_fault=4 with done_addr=req_ea for data), with no memory read.
- R8: Otherwise one read is issued at ptab_base plus the offset. The result is done_kind=1, done_entry equal to the returned word, done_addr=req_ea, done_lpid and done_pid the selected context, and done_perm=0.
- R9: While a read request waits for mem_req_ready, mem_req_valid and mem_req_addr stay unchanged. req_ready stays low from acceptance until the done pulse.
- R10: Every accepted request produces exactly one done pulse, one cycle wide. After reset, done=0, req_ready=1 and mem_req_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_ea | input | ADDR_W | Effective address |
| req_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 data |
| ir_en | input | 1 | Instruction relocation enable |
| dr_en | input | 1 | Data relocation enable |
| part_id | input | LPID_W | Partition ID register |
| proc_id | input | PID_W | Process ID register |
| ptab_base | input | ADDR_W | Process table base address |
| ptab_size | input | SIZE_FLD_W | Table size code, bytes = 2^(code+12) |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | ADDR_W | Read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DATA_W | Read data word |
| done | output | 1 | Result pulse |
| done_kind | output | 2 | 0 real, 1 entry, 2 fault |
| done_addr | output | ADDR_W | Real address, effective address or fault address |
| done_entry | output | DATA_W | Fetched table entry word |
| done_fault | output | 3 | 0 none, 1 inst segment, 2 data segment, 3 inst storage, 4 data storage |
| done_perm | output | 3 | Granted rights {read, write, execute} |
| done_lpid | output | LPID_W | Selected partition ID |
| done_pid | output | PID_W | Selected process ID |

## Verification
The bench targets the off-by-one table bound: offset exactly equal to the table size must fault, and one entry below must read. A design comparing with > instead of >= would read one entry past the table.

It also drives an operating-system quadrant access with a large process ID register value. A design that forgets to force the ID to zero would then fault on the bound, or read the wrong entry.

Other cases cross the enables, such as a fetch with data relocation off, or a store with instruction relocation off. A design that uses the wrong enable returns a real address where a read was due, or the reverse. Real-mode accesses with illegal-quadrant addresses check that real mode wins over the segment check.

Stalled read handshakes with varying delays expose a request that is dropped or changes address while it waits.

// File: rtl/xq_pkg.sv
package xq_pkg;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_DATA3 = 2'd3
   } acc_e;

   typedef enum logic [1:0] {
      RES_REAL  = 2'd0,
      RES_ENTRY = 2'd1,
      RES_FAULT = 2'd2
   } res_e;

   typedef enum logic [2:0] {
      FLT_NONE  = 3'd0,
      FLT_ISEG  = 3'd1,
      FLT_DSEG  = 3'd2,
      FLT_ISTOR = 3'd3,
      FLT_DSTOR = 3'd4
   } flt_e;

   localparam logic [2:0] PERM_ALL  = 3'b111;
   localparam logic [2:0] PERM_NONE = 3'b000;

   localparam logic [1:0] QUAD_APP = 2'd0;
   localparam logic [1:0] QUAD_OS  = 2'd3;

endpackage

// File: rtl/xq_mode_decode.sv
module xq_mode_decode
   import xq_pkg::*;
#(
   parameter int ADDR_W   = 64,
   parameter int LPID_W   = 12,
   parameter int PID_W    = 20,
   parameter int REAL_CLR = 4
) (
   input  logic [ADDR_W-1:0] ea,
   input  logic [1:0]        acc,
   input  logic              ir_en,
   input  logic              dr_en,
   input  logic [LPID_W-1:0] lpid_in,
   input  logic [PID_W-1:0]  pid_in,
   output logic              is_fetch,
   output logic              is_real,
   output logic [ADDR_W-1:0] real_addr,
   output logic              seg_fault,
   output logic [LPID_W-1:0] ctx_lpid,
   output logic [PID_W-1:0]  ctx_pid
);

   localparam int KEEP_W = ADDR_W - REAL_CLR;

   logic [1:0] quad;

   assign quad     = ea[ADDR_W-1 -: 2];
   assign is_fetch = (acc == ACC_FETCH);
   assign is_real  = is_fetch ? !ir_en : !dr_en;

   generate
      if (REAL_CLR == 0) begin : g_no_clear
         assign real_addr = ea;
      end else begin : g_clear
         assign real_addr = {{REAL_CLR{1'b0}}, ea[KEEP_W-1:0]};
      end
   endgenerate

   always_comb begin
      seg_fault = 1'b0;
      ctx_lpid  = lpid_in;
      ctx_pid   = '0;
      unique case (quad)
         QUAD_APP: ctx_pid   = pid_in;
         QUAD_OS:  ctx_pid   = '0;
         default:  seg_fault = 1'b1;
      endcase
   end

endmodule

// File: rtl/xq_bound_check.sv
module xq_bound_check #(
   parameter int ADDR_W      = 64,
   parameter int PID_W       = 20,
   parameter int ENTRY_SHIFT = 4,
   parameter int SIZE_FLD_W  = 5,
   parameter int SIZE_BIAS   = 12
) (
   input  logic [PID_W-1:0]      pid,
   input  logic [SIZE_FLD_W-1:0] size_fld,
   input  logic [ADDR_W-1:0]     base,
   output logic                  over,
   output logic [ADDR_W-1:0]     entry_addr
);

   localparam int OFF_W   = PID_W + ENTRY_SHIFT;
   localparam int N_SIZES = 1 << SIZE_FLD_W;

   logic [OFF_W-1:0]   offset;
   logic [N_SIZES-1:0] over_vec;

   assign offset = {pid, {ENTRY_SHIFT{1'b0}}};

   // One "offset reaches the table size" flag per size code, then a mux.
   generate
      for (genvar k = 0; k < N_SIZES; k++) begin : g_size
         localparam int SH = k + SIZE_BIAS;
         if (SH >= OFF_W) begin : g_fits
            assign over_vec[k] = 1'b0;
         end else begin : g_cmp
            assign over_vec[k] = |offset[OFF_W-1:SH];
         end
      end
   endgenerate

   assign over       = over_vec[size_fld];
   assign entry_addr = base + ADDR_W'(offset);

endmodule

// File: rtl/xq_seq.sv
module xq_seq
   import xq_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int DATA_W = 64,
   parameter int LPID_W = 12,
   parameter int PID_W  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   output logic              accept,
   input  logic [ADDR_W-1:0] ea,
   input  logic              is_fetch,
   input  logic              is_real,
   input  logic [ADDR_W-1:0] real_addr,
   input  logic              seg_fault,
   input  logic              over,
   input  logic [LPID_W-1:0] ctx_lpid,
   input  logic [PID_W-1:0]  ctx_pid,
   input  logic [ADDR_W-1:0] entry_addr,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data,
   output logic              done,
   output logic [1:0]        done_kind,
   output logic [ADDR_W-1:0] done_addr,
   output logic [DATA_W-1:0] done_entry,
   output logic [2:0]        done_fault,
   output logic [2:0]        done_perm,
   output logic [LPID_W-1:0] done_lpid,
   output logic [PID_W-1:0]  done_pid
);

   typedef enum logic [1:0] {S_IDLE, S_DECIDE, S_ISSUE, S_WAIT} st_e;

   st_e               st_q;
   logic [ADDR_W-1:0] rd_addr_q;
   logic [LPID_W-1:0] hold_lpid_q;
   logic [PID_W-1:0]  hold_pid_q;
   logic              done_q;
   res_e              kind_q;
   flt_e              fault_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] entry_q;
   logic [2:0]        perm_q;
   logic [LPID_W-1:0] lpid_q;
   logic [PID_W-1:0]  pid_q;

   assign req_ready     = (st_q == S_IDLE);
   assign accept        = req_valid && req_ready;
   assign mem_req_valid = (st_q == S_ISSUE);
   assign mem_req_addr  = rd_addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= S_IDLE;
         rd_addr_q   <= '0;
         hold_lpid_q <= '0;
         hold_pid_q  <= '0;
         done_q      <= 1'b0;
         kind_q      <= RES_REAL;
         fault_q     <= FLT_NONE;
         addr_q      <= '0;
         entry_q     <= '0;
         perm_q      <= PERM_NONE;
         lpid_q      <= '0;
         pid_q       <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            S_IDLE: begin
               if (req_valid) st_q <= S_DECIDE;
            end
            S_DECIDE: begin
               if (is_real || seg_fault || over) begin
                  done_q  <= 1'b1;
                  st_q    <= S_IDLE;
                  entry_q <= '0;
                  lpid_q  <= '0;
                  pid_q   <= '0;
                  if (is_real) begin
                     kind_q  <= RES_REAL;
                     fault_q <= FLT_NONE;
                     addr_q  <= real_addr;
                     perm_q  <= PERM_ALL;
                  end else begin
                     kind_q  <= RES_FAULT;
                     perm_q  <= PERM_NONE;
                     addr_q  <= is_fetch ? '0 : ea;
                     if (seg_fault) fault_q <= is_fetch ? FLT_ISEG : FLT_DSEG;
                     else           fault_q <= is_fetch ? FLT_ISTOR : FLT_DSTOR;
                  end
               end else begin
                  st_q        <= S_ISSUE;
                  rd_addr_q   <= entry_addr;
                  hold_lpid_q <= ctx_lpid;
                  hold_pid_q  <= ctx_pid;
               end
            end
            S_ISSUE: begin
               if (mem_req_ready) st_q <= S_WAIT;
            end
            S_WAIT: begin
               if (mem_rsp_valid) begin
                  done_q  <= 1'b1;
                  st_q    <= S_IDLE;
                  kind_q  <= RES_ENTRY;
                  fault_q <= FLT_NONE;
                  addr_q  <= ea;
                  entry_q <= mem_rsp_data;
                  perm_q  <= PERM_NONE;
                  lpid_q  <= hold_lpid_q;
                  pid_q   <= hold_pid_q;
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign done       = done_q;
   assign done_kind  = kind_q;
   assign done_fault = fault_q;
   assign done_addr  = addr_q;
   assign done_entry = entry_q;
   assign done_perm  = perm_q;
   assign done_lpid  = lpid_q;
   assign done_pid   = pid_q;

endmodule

// File: rtl/xlat_ctx_qual.sv
module xlat_ctx_qual
   import xq_pkg::*;
#(
   parameter int ADDR_W      = 64,
   parameter int DATA_W      = 64,
   parameter int LPID_W      = 12,
   parameter int PID_W       = 20,
   parameter int ENTRY_SHIFT = 4,
   parameter int SIZE_FLD_W  = 5,
   parameter int SIZE_BIAS   = 12,
   parameter int REAL_CLR    = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic [ADDR_W-1:0]     req_ea,
   input  logic [1:0]            req_acc,
   input  logic                  ir_en,
   input  logic                  dr_en,
   input  logic [LPID_W-1:0]     part_id,
   input  logic [PID_W-1:0]      proc_id,
   input  logic [ADDR_W-1:0]     ptab_base,
   input  logic [SIZE_FLD_W-1:0] ptab_size,
   output logic                  mem_req_valid,
   input  logic                  mem_req_ready,
   output logic [ADDR_W-1:0]     mem_req_addr,
   input  logic                  mem_rsp_valid,
   input  logic [DATA_W-1:0]     mem_rsp_data,
   output logic                  done,
   output logic [1:0]            done_kind,
   output logic [ADDR_W-1:0]     done_addr,
   output logic [DATA_W-1:0]     done_entry,
   output logic [2:0]            done_fault,
   output logic [2:0]            done_perm,
   output logic [LPID_W-1:0]     done_lpid,
   output logic [PID_W-1:0]      done_pid
);

   localparam int OFF_W = PID_W + ENTRY_SHIFT;

   generate
      if (ADDR_W < 8 || REAL_CLR > ADDR_W - 2) begin : g_bad_addr
         $error("xlat_ctx_qual: ADDR_W too small for quadrant and clear bits");
      end
      if (OFF_W > ADDR_W) begin : g_bad_off
         $error("xlat_ctx_qual: table offset wider than address");
      end
      if (SIZE_FLD_W < 1 || SIZE_FLD_W > 6) begin : g_bad_size
         $error("xlat_ctx_qual: SIZE_FLD_W out of range");
      end
   endgenerate

   logic                  accept;
   logic [ADDR_W-1:0]     ea_q;
   logic [1:0]            acc_q;
   logic                  ir_q;
   logic                  dr_q;
   logic [LPID_W-1:0]     lpid_q;
   logic [PID_W-1:0]      pid_q;
   logic [ADDR_W-1:0]     base_q;
   logic [SIZE_FLD_W-1:0] size_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ea_q   <= '0;
         acc_q  <= '0;
         ir_q   <= 1'b0;
         dr_q   <= 1'b0;
         lpid_q <= '0;
         pid_q  <= '0;
         base_q <= '0;
         size_q <= '0;
      end else if (accept) begin
         ea_q   <= req_ea;
         acc_q  <= req_acc;
         ir_q   <= ir_en;
         dr_q   <= dr_en;
         lpid_q <= part_id;
         pid_q  <= proc_id;
         base_q <= ptab_base;
         size_q <= ptab_size;
      end
   end

   logic              is_fetch;
   logic              is_real;
   logic [ADDR_W-1:0] real_addr;
   logic              seg_fault;
   logic [LPID_W-1:0] ctx_lpid;
   logic [PID_W-1:0]  ctx_pid;
   logic              over;
   logic [ADDR_W-1:0] entry_addr;

   xq_mode_decode #(
      .ADDR_W(ADDR_W), .LPID_W(LPID_W), .PID_W(PID_W), .REAL_CLR(REAL_CLR)
   ) u_decode (
      .ea(ea_q), .acc(acc_q), .ir_en(ir_q), .dr_en(dr_q),
      .lpid_in(lpid_q), .pid_in(pid_q),
      .is_fetch(is_fetch), .is_real(is_real), .real_addr(real_addr),
      .seg_fault(seg_fault), .ctx_lpid(ctx_lpid), .ctx_pid(ctx_pid)
   );

   xq_bound_check #(
      .ADDR_W(ADDR_W), .PID_W(PID_W), .ENTRY_SHIFT(ENTRY_SHIFT),
      .SIZE_FLD_W(SIZE_FLD_W), .SIZE_BIAS(SIZE_BIAS)
   ) u_bound (
      .pid(ctx_pid), .size_fld(size_q), .base(base_q),
      .over(over), .entry_addr(entry_addr)
   );

   xq_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LPID_W(LPID_W), .PID_W(PID_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .accept(accept),
      .ea(ea_q), .is_fetch(is_fetch), .is_real(is_real), .real_addr(real_addr),
      .seg_fault(seg_fault), .over(over),
      .ctx_lpid(ctx_lpid), .ctx_pid(ctx_pid), .entry_addr(entry_addr),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data),
      .done(done), .done_kind(done_kind), .done_addr(done_addr),
      .done_entry(done_entry), .done_fault(done_fault), .done_perm(done_perm),
      .done_lpid(done_lpid), .done_pid(done_pid)
   );

endmodule

// File: rtl/xq_checker.sv
module xq_checker #(
   parameter int ADDR_W   = 64,
   parameter int PID_W    = 20,
   parameter int REAL_CLR = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_ea,
   input logic [1:0]        req_acc,
   input logic              ir_en,
   input logic              dr_en,
   input logic [PID_W-1:0]  proc_id,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic              done,
   input logic [1:0]        done_kind,
   input logic [ADDR_W-1:0] done_addr,
   input logic [2:0]        done_fault,
   input logic [2:0]        done_perm,
   input logic [PID_W-1:0]  done_pid
);

   logic [ADDR_W-1:0] c_ea;
   logic [1:0]        c_acc;
   logic              c_ir;
   logic              c_dr;
   logic [PID_W-1:0]  c_pid;
   logic [1:0]        c_quad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_ea  <= '0;
         c_acc <= '0;
         c_ir  <= 1'b0;
         c_dr  <= 1'b0;
         c_pid <= '0;
      end else if (req_valid && req_ready) begin
         c_ea  <= req_ea;
         c_acc <= req_acc;
         c_ir  <= ir_en;
         c_dr  <= dr_en;
         c_pid <= proc_id;
      end
   end

   assign c_quad = c_ea[ADDR_W-1 -: 2];

   a_r1_real_cond: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_kind == 2'd0) |-> ((c_acc == 2'd2) ? !c_ir : !c_dr));

   a_r2_real_result: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_kind == 2'd0) |->
      (done_perm == 3'b111 && done_addr[ADDR_W-1 -: REAL_CLR] == '0));

   a_r3_app_pid: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_kind == 2'd1 && c_quad == 2'd0) |-> (done_pid == c_pid));

   a_r4_os_pid_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_kind == 2'd1 && c_quad == 2'd3) |-> (done_pid == '0));

   a_r5_iseg_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_kind == 2'd2 && done_fault == 3'd1) |->
      (done_addr == '0 && c_acc == 2'd2));

   a_r6_dseg_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_kind == 2'd2 && done_fault == 3'd2) |-> (done_addr == c_ea));

   a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr)));

   a_r9_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready);

   a_r10_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

bind xlat_ctx_qual xq_checker #(
   .ADDR_W(ADDR_W), .PID_W(PID_W), .REAL_CLR(REAL_CLR)
) u_xq_checker (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_ea(req_ea), .req_acc(req_acc), .ir_en(ir_en), .dr_en(dr_en),
   .proc_id(proc_id), .mem_req_valid(mem_req_valid),
   .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
   .done(done), .done_kind(done_kind), .done_addr(done_addr),
   .done_fault(done_fault), .done_perm(done_perm), .done_pid(done_pid)
);

// File: tb/xlat_ctx_qual_bench.sv
`timescale 1ns/1ps
module xlat_ctx_qual_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [63:0] req_ea = '0;
   logic [1:0]  req_acc = '0;
   logic        ir_en = 1'b0;
   logic        dr_en = 1'b0;
   logic [11:0] part_id = '0;
   logic [19:0] proc_id = '0;
   logic [63:0] ptab_base = '0;
   logic [4:0]  ptab_size = '0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [63:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic        done;
   logic [1:0]  done_kind;
   logic [63:0] done_addr;
   logic [63:0] done_entry;
   logic [2:0]  done_fault;
   logic [2:0]  done_perm;
   logic [11:0] done_lpid;
   logic [19:0] done_pid;

   always #2.5 clk = ~clk;

   xlat_ctx_qual u_xlat_ctx_qual (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_ea(req_ea), .req_acc(req_acc), .ir_en(ir_en), .dr_en(dr_en),
      .part_id(part_id), .proc_id(proc_id), .ptab_base(ptab_base),
      .ptab_size(ptab_size), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .done(done), .done_kind(done_kind), .done_addr(done_addr),
      .done_entry(done_entry), .done_fault(done_fault), .done_perm(done_perm),
      .done_lpid(done_lpid), .done_pid(done_pid)
   );

   typedef struct packed {
      logic [1:0]  kind;
      logic [63:0] addr;
      logic [63:0] entry;
      logic [2:0]  fault;
      logic [2:0]  perm;
      logic [11:0] lpid;
      logic [19:0] pid;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    compared = 0;
   int    mismatched = 0;
   int    exp_reads = 0;
   int    reads = 0;
   int    sent = 0;
   int    dones = 0;
   int    overlap = 0;

   function automatic logic [63:0] memf(input logic [63:0] a);
      return a ^ 64'h5A5A_3C3C_0F0F_9696 ^ {a[31:0], a[63:32]};
   endfunction

   task automatic check(input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Driver: computes the expected result from the requirements, queues it,
   // then presents the request.
   task automatic send(input logic [63:0] ea, input logic [1:0] acc,
                       input logic ir, input logic dr, input logic [11:0] lp,
                       input logic [19:0] pd, input logic [63:0] base,
                       input logic [4:0] fld, input string tag);
      exp_t        e;
      logic        fetch;
      logic [1:0]  q;
      logic [19:0] epid;
      logic [63:0] off;
      logic [63:0] lim;
      e     = '0;
      fetch = (acc == 2'd2);
      q     = ea[63:62];
      if (fetch ? !ir : !dr) begin
         e.kind = 2'd0;
         e.addr = {4'b0, ea[59:0]};
         e.perm = 3'b111;
      end else if (q == 2'd1 || q == 2'd2) begin
         e.kind  = 2'd2;
         e.fault = fetch ? 3'd1 : 3'd2;
         e.addr  = fetch ? 64'd0 : ea;
      end else begin
         epid = (q == 2'd3) ? 20'd0 : pd;
         off  = {40'd0, epid, 4'd0};
         lim  = 64'd1 << (int'(fld) + 12);
         if (off >= lim) begin
            e.kind  = 2'd2;
            e.fault = fetch ? 3'd3 : 3'd4;
            e.addr  = fetch ? 64'd0 : ea;
         end else begin
            e.kind  = 2'd1;
            e.addr  = ea;
            e.entry = memf(base + off);
            e.lpid  = lp;
            e.pid   = epid;
            exp_reads++;
         end
      end
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_ea = ea; req_acc = acc; ir_en = ir; dr_en = dr;
      part_id = lp; proc_id = pd; ptab_base = base; ptab_size = fld;
      req_valid = 1'b1;
      sent++;
      @(negedge clk);
      req_valid = 1'b0;
      req_ea = ~ea; proc_id = ~pd; part_id = ~lp;
   endtask

   // Monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_req_valid && req_ready) overlap++;
         if (done) begin
            exp_t  e;
            string t;
            dones++;
            if (exp_q.size() == 0) begin
               check("R10 unexpected done", 64'd1, 64'd0);
            end else begin
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check({t, " kind"},  {62'd0, done_kind},  {62'd0, e.kind});
               check({t, " addr"},  done_addr,           e.addr);
               check({t, " fault"}, {61'd0, done_fault}, {61'd0, e.fault});
               check({t, " perm"},  {61'd0, done_perm},  {61'd0, e.perm});
               if (e.kind == 2'd1) begin
                  check({t, " entry"}, done_entry,          e.entry);
                  check({t, " lpid"},  {52'd0, done_lpid},  {52'd0, e.lpid});
                  check({t, " pid"},   {44'd0, done_pid},   {44'd0, e.pid});
               end
            end
         end
      end
   end

   // Memory model with varying stall and response delay
   int ph = 0;
   int stall = 0;
   int dly = 0;
   int seqn = 0;
   logic [63:0] paddr = '0;

   always @(negedge clk) begin
      mem_rsp_valid = 1'b0;
      if (rst_n) begin
         case (ph)
            0: if (mem_req_valid) begin
                  if (stall == 0) begin
                     mem_req_ready = 1'b1;
                     paddr = mem_req_addr;
                     reads++;
                     ph = 1;
                  end else stall--;
               end
            default: begin
               mem_req_ready = 1'b0;
               if (dly == 0) begin
                  mem_rsp_valid = 1'b1;
                  mem_rsp_data  = memf(paddr);
                  ph    = 0;
                  seqn++;
                  stall = seqn % 3;
                  dly   = (seqn * 3) % 4;
               end else begin
                  dly--;
                  ph = 2;
               end
            end
         endcase
      end
   end

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog R10 actual=hung expected=all results");
      finish_run();
   end

   localparam logic [63:0] TB = 64'h0000_0040_1000_0000;

   initial begin
      repeat (3) @(negedge clk);
      check("R10 reset done",          {63'd0, done},          64'd0);
      check("R10 reset req_ready",     {63'd0, req_ready},     64'd1);
      check("R10 reset mem_req_valid", {63'd0, mem_req_valid}, 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      send(64'hF123_4567_89AB_CDEF, 2'd2, 1'b0, 1'b1, 12'h011, 20'h5, TB, 5'd0, "R1 R2 fetch ir off");
      send(64'hA000_0000_0000_1238, 2'd0, 1'b1, 1'b0, 12'h011, 20'h5, TB, 5'd0, "R1 R2 load dr off quad2");
      send(64'h4000_0000_0000_0040, 2'd3, 1'b1, 1'b0, 12'h011, 20'h5, TB, 5'd0, "R1 code3 data dr off");
      send(64'h0000_0000_0000_4000, 2'd2, 1'b1, 1'b0, 12'h022, 20'h9, TB, 5'd0, "R1 fetch ir on dr off");
      send(64'h0000_1234_0000_0010, 2'd0, 1'b0, 1'b1, 12'h033, 20'h5, TB, 5'd0, "R3 R8 load quad0");
      send(64'h0000_0000_0000_8000, 2'd1, 1'b0, 1'b1, 12'h7A5, 20'h20, TB, 5'd2, "R3 R8 store quad0");
      send(64'hC000_0000_0000_0100, 2'd1, 1'b0, 1'b1, 12'h0C3, 20'hFFFFF, TB, 5'd0, "R4 store quad3");
      send(64'hFFFF_0000_0000_0000, 2'd2, 1'b1, 1'b1, 12'h0C4, 20'h7, TB, 5'd0, "R4 fetch quad3");
      send(64'h4000_0000_0000_2000, 2'd2, 1'b1, 1'b1, 12'h001, 20'h1, TB, 5'd0, "R5 fetch quad1");
      send(64'h8000_0000_0000_2000, 2'd2, 1'b1, 1'b0, 12'h001, 20'h1, TB, 5'd0, "R5 fetch quad2");
      send(64'h8765_4321_0000_0008, 2'd0, 1'b0, 1'b1, 12'h001, 20'h1, TB, 5'd0, "R6 load quad2");
      send(64'h4ABC_0000_0000_0010, 2'd1, 1'b1, 1'b1, 12'h001, 20'h1, TB, 5'd0, "R6 store quad1");
      send(64'h0000_0000_0000_0020, 2'd0, 1'b0, 1'b1, 12'h002, 20'd256, TB, 5'd0, "R7 load at bound");
      send(64'h0000_0000_0000_0030, 2'd0, 1'b0, 1'b1, 12'h002, 20'd255, TB, 5'd0, "R7 R8 load below bound");
      send(64'h0000_0000_0000_0040, 2'd2, 1'b1, 1'b0, 12'h002, 20'd256, TB, 5'd0, "R7 fetch at bound");
      send(64'h0000_0000_0000_0050, 2'd1, 1'b0, 1'b1, 12'h002, 20'd2048, TB, 5'd3, "R7 store at bound fld3");
      send(64'h0000_0000_0000_0060, 2'd1, 1'b0, 1'b1, 12'h002, 20'd2047, TB, 5'd3, "R7 R8 store below bound fld3");
      send(64'h0000_0000_0000_0070, 2'd0, 1'b0, 1'b1, 12'hFFF, 20'hFFFFF, TB, 5'd12, "R8 full size table");
      send(64'h0000_0000_0000_0080, 2'd0, 1'b0, 1'b1, 12'h100, 20'd1, 64'hFFFF_FFFF_FFFF_FFF0, 5'd0, "R8 base wrap");

      while (exp_q.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
      check("R7 R2 memory read count", 64'(reads), 64'(exp_reads));
      check("R10 done count",          64'(dones), 64'(sent));
      check("R9 busy while reading",   64'(overlap), 64'd0);
      finish_run();
   end

endmodule